// File: doc/BRIEF.md
# Machine Status Register Write Legaliser

This block owns the machine-level status word of a processor hart and turns every software write into a legal value before it is stored. A write may arrive through the full machine view or through the narrower supervisor view. A supervisor-view write is first merged into the stored word under the supervisor visibility mask. Both kinds of write then pass through the same filter. That filter lets only writable fields through and refuses previous-privilege encodings that the hart cannot enter. It also recomputes the summary dirty bit from the floating-point and extension state fields.

The stored word is always visible on one port, and the supervisor view of it on another. Whenever a write actually changes a field that affects address translation, a flush request is raised for exactly one cycle. Trap entry and trap return updates are handled elsewhere. Writes are plain control strobes: the block takes one write in every cycle that `wr_valid` is high and never applies back-pressure, so no ready signal exists. Results appear at the next rising clock edge.

Top module: `mstat_legaliser`

## Requirements
- R1: After reset the stored word has the previous-privilege field (bits 12:11) equal to 3 and every other bit 0. `flush_pulse` is 0.
- R2: A machine-view write updates only SIE (1), MIE (3), SPIE (5), MPIE (7), SPP (8), MPP (12:11), FS (14:13), MPRV (17), SUM (18), MXR (19), TVM (20), TW (21) and TSR (22). Every other bit keeps its old value, including UIE (0), UPIE (4) and XS (16:15). The summary bit is the only exception (R4).
- R3: If the written MPP value is 2, or is 1 while `cfg_smode` is 0, or is 0 while `cfg_umode` is 0, the MPP field keeps its old value. The other fields of that same write still take effect.
- R4: After every write, the top bit (XLEN-1) is 1 exactly when FS equals 3 or XS equals 3, whatever the write data holds in that bit.
- R5: `flush_pulse` is high in the cycle after a write's clock edge only if that write changed the stored MXR, MPP, MPRV or SUM field.
- R6: `sview` always equals the stored word masked to bits 0, 1, 4, 5, 8, 13 to 16, 18, 19 and XLEN-1.
- R7: A write with `wr_sview` high can change only SIE, SPIE, SPP, FS, SUM and MXR (and the summary bit through R4). MIE, MPIE, MPP, MPRV, TVM, TW and TSR stay as they were.
- R8: In cycles with `wr_valid` low the stored word does not change and `flush_pulse` is 0 in the following cycle.
- R9: A write whose only attempted change to MXR, MPP, MPRV and SUM is an MPP value refused under R3 raises no flush request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe, one write per cycle it is high |
| wr_sview | input | 1 | 1: write through the supervisor view, 0: machine view |
| wr_data | input | XLEN | Write data |
| cfg_smode | input | 1 | Supervisor privilege level implemented |
| cfg_umode | input | 1 | User privilege level implemented |
| status_q | output | XLEN | Stored machine status word |
| sview | output | XLEN | Supervisor view of the stored word |
| flush_pulse | output | 1 | One-cycle translation flush request |

## Verification
On every cycle the assertions check several properties. The summary bit must agree with FS and XS. MPP must never hold 2. Idle cycles must leave the word untouched. Writes may touch only writable bits, and supervisor-view writes may not touch machine-only fields. The flush pulse must follow exactly from a change in the translation-relevant fields. Some properties depend on the configuration inputs and on chosen data, so only the bench scenarios can show them. These are the refusal of encodings for absent privilege levels, the absence of a flush when only an MPP value was refused, and the exact values after full-ones and mixed writes through both views.

// File: rtl/mst_pkg.sv
package mst_pkg;
  localparam int UIE_B  = 0;
  localparam int SIE_B  = 1;
  localparam int MIE_B  = 3;
  localparam int UPIE_B = 4;
  localparam int SPIE_B = 5;
  localparam int MPIE_B = 7;
  localparam int SPP_B  = 8;
  localparam int MPP_LO = 11;
  localparam int FS_LO  = 13;
  localparam int XS_LO  = 15;
  localparam int MPRV_B = 17;
  localparam int SUM_B  = 18;
  localparam int MXR_B  = 19;
  localparam int TVM_B  = 20;
  localparam int TW_B   = 21;
  localparam int TSR_B  = 22;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  // fields software may change through the machine view (summary bit excluded)
  function automatic logic [63:0] wr_mask64();
    logic [63:0] m;
    m = '0;
    m[SIE_B] = 1'b1;  m[MIE_B] = 1'b1;  m[SPIE_B] = 1'b1; m[MPIE_B] = 1'b1;
    m[SPP_B] = 1'b1;  m[MPP_LO +: 2] = 2'b11; m[FS_LO +: 2] = 2'b11;
    m[MPRV_B] = 1'b1; m[SUM_B] = 1'b1;  m[MXR_B] = 1'b1;
    m[TVM_B] = 1'b1;  m[TW_B] = 1'b1;   m[TSR_B] = 1'b1;
    return m;
  endfunction

  // bits visible through the supervisor view, summary bit at xlen-1
  function automatic logic [63:0] sv_mask64(int xlen);
    logic [63:0] m;
    m = '0;
    m[UIE_B] = 1'b1;  m[SIE_B] = 1'b1;  m[UPIE_B] = 1'b1; m[SPIE_B] = 1'b1;
    m[SPP_B] = 1'b1;  m[FS_LO +: 2] = 2'b11; m[XS_LO +: 2] = 2'b11;
    m[SUM_B] = 1'b1;  m[MXR_B] = 1'b1;
    m[xlen-1] = 1'b1;
    return m;
  endfunction

  // fields whose change invalidates cached translations
  function automatic logic [63:0] xlate_mask64();
    logic [63:0] m;
    m = '0;
    m[MXR_B] = 1'b1; m[MPP_LO +: 2] = 2'b11; m[MPRV_B] = 1'b1; m[SUM_B] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/mst_view_merge.sv
module mst_view_merge #(
  parameter int XLEN = 64
) (
  input  logic            use_sview,
  input  logic [XLEN-1:0] cur_word,
  input  logic [XLEN-1:0] req_data,
  output logic [XLEN-1:0] merged
);
  localparam logic [XLEN-1:0] SMASK = XLEN'(mst_pkg::sv_mask64(XLEN));

  always_comb begin
    if (use_sview) merged = (cur_word & ~SMASK) | (req_data & SMASK);
    else           merged = req_data;
  end
endmodule

// File: rtl/mst_legalize.sv
module mst_legalize #(
  parameter int XLEN = 64
) (
  input  logic            cfg_smode,
  input  logic            cfg_umode,
  input  logic [XLEN-1:0] cur_word,
  input  logic [XLEN-1:0] merged,
  output logic [XLEN-1:0] next_word
);
  import mst_pkg::*;
  localparam int SD_B = XLEN - 1;
  localparam logic [XLEN-1:0] WMASK = XLEN'(wr_mask64());
  localparam logic [XLEN-1:0] MPP_M = XLEN'(64'h3 << MPP_LO);

  priv_e           req_mpp;
  logic            mpp_bad;
  logic [XLEN-1:0] eff_mask;
  logic [XLEN-1:0] body;

  always_comb begin
    req_mpp = priv_e'(merged[MPP_LO +: 2]);
    unique case (req_mpp)
      PRIV_RSVD:  mpp_bad = 1'b1;
      PRIV_SUPER: mpp_bad = !cfg_smode;
      PRIV_USER:  mpp_bad = !cfg_umode;
      default:    mpp_bad = 1'b0;
    endcase
    eff_mask = mpp_bad ? (WMASK & ~MPP_M) : WMASK;
  end

  for (genvar i = 0; i < SD_B; i++) begin : g_bit
    assign body[i] = eff_mask[i] ? merged[i] : cur_word[i];
  end
  assign body[SD_B] = 1'b0;

  always_comb begin
    next_word       = body;
    next_word[SD_B] = (body[FS_LO +: 2] == 2'b11) || (body[XS_LO +: 2] == 2'b11);
  end
endmodule

// File: rtl/mst_flush_detect.sv
module mst_flush_detect #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [XLEN-1:0] cur_word,
  input  logic [XLEN-1:0] next_word,
  output logic            flush_pulse
);
  localparam logic [XLEN-1:0] CRIT = XLEN'(mst_pkg::xlate_mask64());

  logic hit;
  assign hit = |((cur_word ^ next_word) & CRIT);

  always_ff @(posedge clk) begin
    if (!rst_n) flush_pulse <= 1'b0;
    else        flush_pulse <= fire && hit;
  end
endmodule

// File: rtl/mstat_legaliser.sv
module mstat_legaliser #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  input  logic            wr_sview,
  input  logic [XLEN-1:0] wr_data,
  input  logic            cfg_smode,
  input  logic            cfg_umode,
  output logic [XLEN-1:0] status_q,
  output logic [XLEN-1:0] sview,
  output logic            flush_pulse
);
  localparam logic [XLEN-1:0] SMASK = XLEN'(mst_pkg::sv_mask64(XLEN));
  localparam logic [XLEN-1:0] RST_WORD = XLEN'(64'h3 << mst_pkg::MPP_LO);

  logic [XLEN-1:0] merged;
  logic [XLEN-1:0] next_word;

  mst_view_merge #(.XLEN(XLEN)) u_merge (
    .use_sview (wr_sview),
    .cur_word  (status_q),
    .req_data  (wr_data),
    .merged    (merged)
  );

  mst_legalize #(.XLEN(XLEN)) u_legal (
    .cfg_smode (cfg_smode),
    .cfg_umode (cfg_umode),
    .cur_word  (status_q),
    .merged    (merged),
    .next_word (next_word)
  );

  mst_flush_detect #(.XLEN(XLEN)) u_flush (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (wr_valid),
    .cur_word    (status_q),
    .next_word   (next_word),
    .flush_pulse (flush_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        status_q <= RST_WORD;
    else if (wr_valid) status_q <= next_word;
  end

  assign sview = status_q & SMASK;
endmodule

// File: rtl/mstat_legaliser_chk.sv
module mstat_legaliser_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_valid,
  input logic            wr_sview,
  input logic [XLEN-1:0] status_q,
  input logic            flush_pulse
);
  import mst_pkg::*;
  localparam logic [XLEN-1:0] WSD  = XLEN'(wr_mask64()) | (XLEN'(1) << (XLEN-1));
  localparam logic [XLEN-1:0] CRIT = XLEN'(xlate_mask64());
  localparam logic [XLEN-1:0] MONLY = XLEN'((64'h1 << MIE_B) | (64'h1 << MPIE_B) |
    (64'h3 << MPP_LO) | (64'h1 << MPRV_B) | (64'h1 << TVM_B) | (64'h1 << TW_B) |
    (64'h1 << TSR_B));

  // R2: only writable bits (plus summary) may move on a write
  a_r2_ro_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> (((status_q ^ $past(status_q)) & ~WSD) == '0));

  // R3: reserved previous-privilege encoding is never stored
  a_r3_mpp_not_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[MPP_LO +: 2] != 2'b10);

  // R4: summary bit tracks FS and XS
  a_r4_sd_summary: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[XLEN-1] == ((status_q[FS_LO +: 2] == 2'b11) || (status_q[XLEN > 16 ? XS_LO : 0 +: 2] == 2'b11)));

  // R5: flush follows a change of translation-relevant fields
  a_r5_flush_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> (flush_pulse == (((status_q ^ $past(status_q)) & CRIT) != '0)));

  // R7: supervisor-view write leaves machine-only fields alone
  a_r7_sview_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sview) |=> (((status_q ^ $past(status_q)) & MONLY) == '0));

  // R8: idle cycle holds the word and raises no flush
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> ($stable(status_q) && !flush_pulse));
endmodule

bind mstat_legaliser mstat_legaliser_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .wr_sview    (wr_sview),
  .status_q    (status_q),
  .flush_pulse (flush_pulse)
);

// File: tb/mstat_legaliser_bench.sv
module mstat_legaliser_bench;
  localparam int XLEN = 64;
  localparam logic [63:0] WM = 64'h0000_0000_007E_79AA; // SIE,MIE,SPIE,MPIE,SPP,MPP,FS,MPRV..TSR
  localparam logic [63:0] SM = 64'h8000_0000_000D_E133; // sview bits
  localparam logic [63:0] CR = 64'h0000_0000_000E_1800; // MXR,MPP,MPRV,SUM
  localparam logic [63:0] MPPM = 64'h1800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_sview = 1'b0, cfg_smode = 1'b1, cfg_umode = 1'b1;
  logic [XLEN-1:0] wr_data = '0;
  logic [XLEN-1:0] status_q, sview;
  logic flush_pulse;
  int checks = 0, errors = 0;
  logic [63:0] expw;
  logic expf;

  always #2 clk = ~clk;

  mstat_legaliser #(.XLEN(XLEN)) u_mstat_legaliser (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sview(wr_sview),
    .wr_data(wr_data), .cfg_smode(cfg_smode), .cfg_umode(cfg_umode),
    .status_q(status_q), .sview(sview), .flush_pulse(flush_pulse));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected next word from the requirements (R2,R3,R4,R7)
  function automatic logic [63:0] model(logic [63:0] old, logic [63:0] d, logic sv,
                                        logic s, logic u);
    logic [63:0] mg, m, n;
    logic drop;
    mg = sv ? ((old & ~SM) | (d & SM)) : d;
    drop = (mg[12:11] == 2'd2) || (mg[12:11] == 2'd1 && !s) || (mg[12:11] == 2'd0 && !u);
    m = drop ? (WM & ~MPPM) : WM;
    n = (old & ~m) | (mg & m);
    n[63] = (n[14:13] == 2'b11) || (n[16:15] == 2'b11);
    return n;
  endfunction

  // one write, then sample at the following falling edge
  task automatic do_write(logic sv, logic [63:0] d);
    logic [63:0] old;
    old = status_q;
    expw = model(old, d, sv, cfg_smode, cfg_umode);
    expf = ((old ^ expw) & CR) != 0;
    @(negedge clk);
    wr_valid = 1'b1; wr_sview = sv; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset word", status_q, 64'h1800);
    check("R1 reset flush", {63'd0, flush_pulse}, 64'd0);
    check("R6 reset sview", sview, 64'd0);
  endtask

  task automatic t_all_ones;
    do_write(1'b0, '1);
    check("R2 all-ones write", status_q, 64'h8000_0000_007E_79AA);
    check("R5 flush after MXR/SUM/MPRV set", {63'd0, flush_pulse}, 64'd1);
    check("R6 sview after all-ones", sview, 64'h8000_0000_000C_6122);
    do_write(1'b0, '0);
    check("R2 all-zero write", status_q, expw);
  endtask

  task automatic t_mpp;
    do_write(1'b0, 64'h1800);
    do_write(1'b0, 64'h1008);               // MPP=2, MIE=1
    check("R3 rsvd MPP kept", status_q, 64'h1808);
    check("R9 refused MPP no flush", {63'd0, flush_pulse}, 64'd0);
    cfg_smode = 1'b0;
    do_write(1'b0, 64'h0800);
    check("R3 MPP=S refused without S", status_q, 64'h1800);
    cfg_smode = 1'b1; cfg_umode = 1'b0;
    do_write(1'b0, 64'h0000);
    check("R3 MPP=U refused without U", status_q, 64'h1800);
    cfg_umode = 1'b1;
    do_write(1'b0, 64'h0800);
    check("R3 MPP=S accepted", status_q, 64'h0800);
    check("R5 flush on MPP change", {63'd0, flush_pulse}, 64'd1);
  endtask

  task automatic t_sd;
    do_write(1'b0, 64'h6000);
    check("R4 FS=3 sets SD", status_q, 64'h8000_0000_0000_6000);
    do_write(1'b0, 64'h8000_0000_0000_2000);
    check("R4 SD not writable, FS=1", status_q, 64'h2000);
    do_write(1'b0, 64'h8000_0000_0001_8000);
    check("R4 XS write ignored, SD clear", status_q, 64'h0);
  endtask

  task automatic t_sview;
    do_write(1'b0, 64'h0000_1800);
    do_write(1'b1, '1);
    check("R7 sview write of ones", status_q, expw);
    check("R7 MIE/MPP untouched", status_q & 64'h0070_1888, 64'h1800);
    check("R6 sview output", sview, expw & SM);
    check("R5 flush after sview SUM/MXR", {63'd0, flush_pulse}, {63'd0, expf});
  endtask

  task automatic t_idle;
    logic [63:0] held;
    held = status_q;
    @(negedge clk); wr_data = 64'h0000_0000_000E_0000; wr_sview = 1'b0;
    @(negedge clk); wr_data = '1;
    @(negedge clk);
    check("R8 idle holds word", status_q, held);
    check("R8 idle no flush", {63'd0, flush_pulse}, 64'd0);
  endtask

  task automatic t_flush_fields;
    do_write(1'b0, 64'h1800);
    do_write(1'b0, 64'h1800 | (64'h1 << 19));
    check("R5 MXR flush", {63'd0, flush_pulse}, 64'd1);
    do_write(1'b0, 64'h1800 | (64'h1 << 17));
    check("R5 MPRV/MXR flush", {63'd0, flush_pulse}, 64'd1);
    do_write(1'b0, 64'h1800 | (64'h1 << 17) | (64'h1 << 20));
    check("R5 TVM only no flush", {63'd0, flush_pulse}, 64'd0);
    do_write(1'b0, 64'h1800 | (64'h1 << 17) | (64'h1 << 20) | (64'h1 << 18));
    check("R5 SUM flush", {63'd0, flush_pulse}, 64'd1);
    @(negedge clk);
    check("R5 pulse lasts one cycle", {63'd0, flush_pulse}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_ones();
    t_mpp();
    t_sd();
    t_sview();
    t_idle();
    t_flush_fields();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule